// File: doc/BRIEF.md
# USB Frame-End Interrupt Timer

This block measures elapsed time inside each 1 ms full-speed USB frame and raises a late-frame interrupt. It counts clock cycles of the 48 MHz controller clock, starting from zero at every start-of-frame pulse. When the count reaches a programmable fraction of the frame, it sets a sticky flag. Software reads the flag to decide whether the isochronous (periodic) work for the current frame has finished in time.

A 2-bit code selects the fraction: 80, 85, 90 or 95 percent of the frame. The code is meant to be written once during configuration. The flag fires at most once per frame and stays set until software strobes the clear input. When start-of-frame pulses stop arriving, the counter holds at the last cycle of the frame instead of wrapping.

Top module: `usb_frame_end_timer`

## Requirements
- R1: While the synchronous active-low reset is low, the next clock edge sets `frame_cnt` to 0 and `irq_flag` to 0.
- R2: A clock edge with `sof` high loads `frame_cnt` with 0 and re-arms the interrupt for the new frame.
- R3: A clock edge with `sof` low increments `frame_cnt` by exactly one while it is below FRAME_CYCLES-1.
- R4: With no `sof`, `frame_cnt` saturates at FRAME_CYCLES-1 (47999 by default) and never wraps.
- R5: The threshold is FRAME_CYCLES*(80+5*`frac_sel`)/100. With the default, `frac_sel`=0 gives 38400, 1 gives 40800, 2 gives 43200 and 3 gives 45600 cycles.
- R6: `irq_flag` rises on the clock edge at which `frame_cnt` equals the selected threshold. It is therefore first seen high together with `frame_cnt` = threshold+1.
- R7: The interrupt sets at most once per frame, even if `frac_sel` changes mid-frame to a threshold that has not been passed yet.
- R8: `irq_flag` is sticky. It stays high, across frame boundaries as well, until an edge with `irq_clr` high and no new set.
- R9: When the set condition and `irq_clr` arrive on the same edge, the set wins and `irq_flag` is high afterwards.
- R10: An edge with `sof` high does not set the flag, even if `frame_cnt` equals the threshold on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock, 48 MHz at full speed |
| rst_n | input | 1 | Synchronous active-low reset |
| sof | input | 1 | One-cycle start-of-frame pulse; restarts the count |
| frac_sel | input | 2 | Frame fraction code for the interrupt point |
| irq_clr | input | 1 | Clear strobe for the interrupt flag |
| irq_flag | output | 1 | Sticky frame-end interrupt flag |
| frame_cnt | output | $clog2(FRAME_CYCLES) | Cycles elapsed since the last start-of-frame |

## Verification
The bench uses a 200-cycle frame and sweeps all four fraction codes. For each code it measures the exact cycle at which the flag rises, so a design with a wrong percentage table or an extra register stage shows up as a fire at the wrong cycle. It lets the counter run past the frame end to catch a counter that wraps, and therefore a second fire in the same frame. It also changes the fraction code mid-frame to catch a design that re-fires at the later threshold. Finally, it lands a clear and a start-of-frame exactly on the threshold edge, exposing a clear that wrongly beats the set and a start-of-frame that fails to suppress firing.

// File: rtl/usb_fe_pkg.sv
// Package: shared constants and helpers for the frame-end interrupt timer.
// Assumes frame lengths small enough that frame*95 fits in a 32-bit int.
package usb_fe_pkg;

    localparam int FE_SEL_W    = 2;
    localparam int FE_NUM_FRAC = 1 << FE_SEL_W;
    localparam int FE_BASE_PCT = 80;
    localparam int FE_STEP_PCT = 5;

    // Threshold in cycles for a given fraction code.
    function automatic int frac_threshold(input int frame_cycles, input int code);
        return (frame_cycles * (FE_BASE_PCT + FE_STEP_PCT * code)) / 100;
    endfunction

endpackage

// File: rtl/fe_cycle_counter.sv
// Module: in-frame cycle counter.
// Restarts at 0 on a start-of-frame pulse, counts up one per clock and
// saturates at FRAME_CYCLES-1. Assumes sof is a single-cycle pulse.
module fe_cycle_counter #(
    parameter int FRAME_CYCLES = 48000,
    localparam int CNT_W = $clog2(FRAME_CYCLES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_CYCLES - 1);

    // Counter update: restart, step or hold at the saturation point.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (sof)
            cnt <= '0;
        else if (cnt != CNT_MAX)
            cnt <= cnt + CNT_W'(1);
    end

    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0));

    a_r2_sof_restart: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> (cnt == '0));

    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!sof && cnt != CNT_MAX) |=> (cnt == $past(cnt) + CNT_W'(1)));

    a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (!sof && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

endmodule

// File: rtl/fe_threshold_sel.sv
// Module: fraction threshold table and compare.
// Builds the four thresholds from the frame length at elaboration and
// flags the cycle on which the count equals the selected one.
module fe_threshold_sel #(
    parameter int FRAME_CYCLES = 48000,
    localparam int CNT_W = $clog2(FRAME_CYCLES)
) (
    input  logic [usb_fe_pkg::FE_SEL_W-1:0] frac_sel,
    input  logic [CNT_W-1:0]                cnt,
    output logic                            at_thr
);

    logic [CNT_W-1:0] thr_tab [usb_fe_pkg::FE_NUM_FRAC];

    // One table entry per fraction code.
    for (genvar g = 0; g < usb_fe_pkg::FE_NUM_FRAC; g++) begin : g_thr
        assign thr_tab[g] = CNT_W'(usb_fe_pkg::frac_threshold(FRAME_CYCLES, g));
    end

    // Compare the running count against the selected threshold.
    always_comb at_thr = (cnt == thr_tab[frac_sel]);

endmodule

// File: rtl/fe_irq_flag.sv
// Module: once-per-frame arming and sticky interrupt flag.
// Set wins over clear; a start-of-frame edge re-arms and never sets.
module fe_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic sof,
    input  logic at_thr,
    input  logic irq_clr,
    output logic irq_flag
);

    logic armed;
    logic fire;

    // Fire only when armed and not on a frame-restart edge.
    always_comb fire = armed && at_thr && !sof;

    // Arming: re-armed each frame, spent by the first fire.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b1;
        else if (sof)
            armed <= 1'b1;
        else if (fire)
            armed <= 1'b0;
    end

    // Sticky flag with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_flag <= 1'b0;
        else if (fire)
            irq_flag <= 1'b1;
        else if (irq_clr)
            irq_flag <= 1'b0;
    end

    a_r1_flag_reset: assert property (@(posedge clk)
        !rst_n |=> !irq_flag);

    a_r6_set_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && at_thr && !sof) |=> irq_flag);

    a_r7_spent_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !sof) |=> !armed);

    a_r7_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && at_thr && !sof) |=> !armed);

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);

    a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && irq_clr) |=> irq_flag);

    a_r10_sof_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (sof && !irq_flag) |=> !irq_flag);

endmodule

// File: rtl/usb_frame_end_timer.sv
// Top: full-speed frame-end interrupt timer.
// Counts controller clocks from each start-of-frame and raises a sticky
// interrupt at 80/85/90/95 % of the frame. Assumes frac_sel is static
// after configuration (a mid-frame change still fires at most once).
module usb_frame_end_timer #(
    parameter int FRAME_CYCLES = 48000,
    localparam int CNT_W = $clog2(FRAME_CYCLES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic [1:0]       frac_sel,
    input  logic             irq_clr,
    output logic             irq_flag,
    output logic [CNT_W-1:0] frame_cnt
);

    logic at_thr;

    fe_cycle_counter #(.FRAME_CYCLES(FRAME_CYCLES)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .sof   (sof),
        .cnt   (frame_cnt)
    );

    fe_threshold_sel #(.FRAME_CYCLES(FRAME_CYCLES)) u_thr (
        .frac_sel (frac_sel),
        .cnt      (frame_cnt),
        .at_thr   (at_thr)
    );

    fe_irq_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .sof      (sof),
        .at_thr   (at_thr),
        .irq_clr  (irq_clr),
        .irq_flag (irq_flag)
    );

endmodule

// File: tb/usb_frame_end_timer_bench.sv
// Bench: small 200-cycle frame; a cycle model built from the requirements
// is compared every cycle, plus directed checks of fire timing per code.
module usb_frame_end_timer_bench;

    localparam int F = 200;
    localparam int W = $clog2(F);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sof = 1'b0;
    logic [1:0]   frac_sel = 2'd0;
    logic         irq_clr = 1'b0;
    logic         irq_flag;
    logic [W-1:0] frame_cnt;

    int checks = 0;
    int errors = 0;

    usb_frame_end_timer #(.FRAME_CYCLES(F)) u_usb_frame_end_timer (
        .clk(clk), .rst_n(rst_n), .sof(sof), .frac_sel(frac_sel),
        .irq_clr(irq_clr), .irq_flag(irq_flag), .frame_cnt(frame_cnt)
    );

    always #10 clk = ~clk;

    // Reference model from the requirements.
    int m_cnt = 0;
    bit m_arm = 1'b1;
    bit m_flag = 1'b0;
    int m_thr;
    bit m_hit;
    always_comb m_thr = F * (80 + 5 * int'(frac_sel)) / 100;
    always_comb m_hit = m_arm && !sof && (m_cnt == m_thr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= 0; m_arm <= 1'b1; m_flag <= 1'b0;
        end else begin
            m_cnt  <= sof ? 0 : ((m_cnt == F - 1) ? m_cnt : m_cnt + 1);
            m_arm  <= sof ? 1'b1 : (m_hit ? 1'b0 : m_arm);
            m_flag <= m_hit ? 1'b1 : (irq_clr ? 1'b0 : m_flag);
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock: apply inputs, then compare at the following falling edge.
    task automatic cyc(input bit s, input bit c);
        sof = s; irq_clr = c;
        @(posedge clk);
        @(negedge clk);
        sof = 1'b0; irq_clr = 1'b0;
        check("R3 count vs model", int'(frame_cnt), m_cnt);
        check("R8 flag vs model", int'(irq_flag), int'(m_flag));
    endtask

    initial begin
        int exp_fire [4] = '{161, 171, 181, 191};
        int n;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset count", int'(frame_cnt), 0);
        check("R1 reset flag", int'(irq_flag), 0);
        rst_n = 1'b1;

        // R5/R6/R4/R8 sweep over every fraction code
        for (int s = 0; s < 4; s++) begin
            frac_sel = 2'(s);
            cyc(1'b1, 1'b1);
            check("R2 count after sof", int'(frame_cnt), 0);
            n = 0;
            while (!irq_flag && n < F + 5) begin
                cyc(1'b0, 1'b0);
                n++;
            end
            check("R5 R6 fire cycle", n, exp_fire[s]);
            check("R6 count at first flag", int'(frame_cnt), exp_fire[s]);
            repeat (F) cyc(1'b0, 1'b0);
            check("R4 saturated count", int'(frame_cnt), F - 1);
            check("R7 R8 flag held", int'(irq_flag), 1);
            cyc(1'b0, 1'b1);
            check("R8 cleared", int'(irq_flag), 0);
            repeat (5) cyc(1'b0, 1'b0);
            check("R7 no refire", int'(irq_flag), 0);
        end

        // R7: code raised mid-frame after firing does not fire again
        frac_sel = 2'd0;
        cyc(1'b1, 1'b0);
        repeat (165) cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b1);
        frac_sel = 2'd3;
        repeat (F) cyc(1'b0, 1'b0);
        check("R7 single fire after code change", int'(irq_flag), 0);

        // R9: clear on the set edge (count==170 with code 1)
        frac_sel = 2'd1;
        cyc(1'b1, 1'b0);
        repeat (170) cyc(1'b0, 1'b0);
        check("R9 at threshold, not yet set", int'(irq_flag), 0);
        cyc(1'b0, 1'b1);
        check("R9 set beats clear", int'(irq_flag), 1);

        // R8: sticky across a new frame
        cyc(1'b1, 1'b0);
        check("R8 sticky over sof", int'(irq_flag), 1);
        cyc(1'b0, 1'b1);

        // R10: sof exactly on the threshold edge (count==180, code 2)
        frac_sel = 2'd2;
        cyc(1'b1, 1'b0);
        repeat (180) cyc(1'b0, 1'b0);
        cyc(1'b1, 1'b0);
        check("R10 no set on sof edge", int'(irq_flag), 0);
        check("R2 restart on threshold", int'(frame_cnt), 0);
        repeat (181) cyc(1'b0, 1'b0);
        check("R2 re-armed fires", int'(irq_flag), 1);

        // R1: mid-run reset
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 mid-run reset count", int'(frame_cnt), 0);
        check("R1 mid-run reset flag", int'(irq_flag), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule